// File: doc/BRIEF.md
# NAND Flash Host Front-End

This block connects a simple processor register bus to an 8-bit NAND flash device. Software configures strobe timing and geometry through a control register, watches progress through a live status register and a sticky event register, and pushes work into a small write buffer. Every byte that goes to the flash passes through this buffer: command bytes, address bytes and data bytes, plus read requests. The buffer is drained strictly in arrival order. A dedicated sequencer turns each entry into one strobe cycle on the flash pins.

A write entry produces one low pulse on the write strobe. During that pulse the latch-enable line that matches the entry kind is held high and the data bus is driven. A read is split into a request and a response. Software writes any value to the read-request register. When the sequencer reaches that entry, it pulses the read strobe and samples the flash data as the strobe rises. It then places the byte in the read-data register and sets a sticky read-ready flag. Reads are held back while the device reports busy. The ready/busy input passes through a two-flop synchronizer, and its rising edges are recorded as events. A self-clearing bit starts a reset of a neighbouring checksum engine. The page-size and bus-width selections are passed out to that engine.

Top module: `nand_host_fe`

## Requirements
- R1: The control register (offset 0) holds the write strobe delay in bits 3:0, the read strobe delay in bits 7:4, the width select in bit 8 and the page-size select in bit 9 (1 = 512-byte pages). Bits 15:10 read as zero. It resets to zero. Bits 8 and 9 appear on `cfg_wide16_o` and `cfg_pg512_o`.
- R2: The status register (offset 1) reads bit 0 = synchronized device ready, bit 1 = buffer full, bit 2 = data write pending, bit 3 = read pending, bit 4 = buffer empty, and zero elsewhere. After reset with the device ready it reads 0x0011.
- R3: Writes to offsets 4 (command), 5 (address) and 6 (data) are sent to the flash in the order they were written. A command asserts CLE only, an address asserts ALE only and data asserts neither, with the written byte on the data bus during the write strobe.
- R4: Each write strobe low pulse lasts exactly (write delay + 1) clock cycles.
- R5: A write to offset 7 queues one read. The read strobe is low for exactly (read delay + 1) cycles, and the byte present when the strobe rises is returned in bits 7:0 of offset 8. Event bit 3 (read ready) then sets, and status bit 3 is high while the read is queued.
- R6: A queued read does not start while the synchronized ready line is low.
- R7: The buffer holds 4 entries. A queue write that arrives while the buffer is full is dropped and sets event bit 1 (overflow).
- R8: Event bit 2 sets when the buffer goes from full to not full.
- R9: Event bit 0 sets on the third clock edge after the ready input rises, after two synchronizer flops and an edge detector.
- R10: Status bit 2 is high while a data entry is queued or being sent. Event bit 4 (page write done) sets when a data write finishes and no other data entry is queued.
- R11: The event register is at offset 2. Writing 1 to a bit clears it, writing 0 leaves it, and a new event in the same cycle wins over the clear.
- R12: The mask register (offset 3, bits 4:0) resets to zero. `irq_o` is the OR of the event bits that are enabled by the mask.
- R13: Writing 1 to bit 0 of offset 9 makes that bit read 1 for exactly 6 cycles (ECC_RST_CYC), after which it clears itself. `ecc_rst_o` follows the bit.
- R14: Chip enable (`nf_ce_n_o`) is low whenever an entry is queued or being sent, and high when the front-end is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Masked event interrupt |
| ecc_rst_o | output | 1 | Reset request to the checksum engine |
| cfg_wide16_o | output | 1 | Width select from the control register |
| cfg_pg512_o | output | 1 | Page-size select from the control register |
| nf_ce_n_o | output | 1 | Flash chip enable, active low |
| nf_cle_o | output | 1 | Command latch enable |
| nf_ale_o | output | 1 | Address latch enable |
| nf_we_n_o | output | 1 | Write strobe, active low |
| nf_re_n_o | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data bus out |
| nf_dq_oe_o | output | 1 | Data bus output enable |
| nf_dq_i | input | 8 | Data bus in |
| nf_rb_i | input | 1 | Device ready (high) / busy (low) |

## Verification
The bench fills the buffer with read requests while the device is busy, then writes one more entry. A design that accepted that fifth write would emit five read strobes instead of four, and one that ignored the busy line would pulse the read strobe too early. Strobe widths are measured at the pins for random delay settings, including zero and fifteen. An off-by-one delay counter would show up as a pulse that is one cycle too long or too short. The event register is checked bit by bit after partial clears and at the exact cycle the ready edge reaches it. This exposes a missing synchronizer stage, a clear that hits the wrong bits, and a page-done flag raised while data is still queued.

// File: rtl/nhf_pkg.sv
package nhf_pkg;
  // Entry kinds; the encoding equals the low two bits of the queue register offset
  typedef enum logic [1:0] {
    K_CMD  = 2'b00,
    K_ADDR = 2'b01,
    K_DWR  = 2'b10,
    K_RREQ = 2'b11
  } ent_kind_e;

  typedef struct packed {
    ent_kind_e   kind;
    logic [7:0]  val;
  } wb_ent_t;

  localparam int RA_W = 4;
  localparam logic [RA_W-1:0] RA_CTRL = 4'd0;
  localparam logic [RA_W-1:0] RA_STAT = 4'd1;
  localparam logic [RA_W-1:0] RA_EVT  = 4'd2;
  localparam logic [RA_W-1:0] RA_MASK = 4'd3;
  localparam logic [RA_W-1:0] RA_RDAT = 4'd8;
  localparam logic [RA_W-1:0] RA_ECCR = 4'd9;

  localparam int EV_NBSY  = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_EDGE  = 2;
  localparam int EV_RDRDY = 3;
  localparam int EV_WDONE = 4;
  localparam int EV_W     = 5;

  localparam int CT_W  = 10;
  localparam int DLY_W = 4;
endpackage

// File: rtl/nhf_sync.sv
module nhf_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  // Reset to 1: the device is assumed ready, so no edge is reported at start-up
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~s3_q;
endmodule

// File: rtl/nhf_wbuf.sv
module nhf_wbuf
  import nhf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk_i,
  input  logic    rst_n_i,
  input  logic    push_i,
  input  wb_ent_t push_ent_i,
  input  logic    pop_i,
  output wb_ent_t head_o,
  output logic    full_o,
  output logic    empty_o,
  output logic    has_dwr_o,
  output logic    has_rreq_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] dwr_hit, rrq_hit;
  wb_ent_t          mem_q [DEPTH];
  logic             push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (pop_ok) begin
      rp_d        = ptr_inc(rp_q);
      vld_d[rp_q] = 1'b0;
    end
    if (push_ok) begin
      wp_d        = ptr_inc(wp_q);
      vld_d[wp_q] = 1'b1;
    end
    if (push_ok && !pop_ok)      cnt_d = cnt_q + CW'(1);
    else if (!push_ok && pop_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  // Storage carries no reset; the valid bits qualify it
  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= push_ent_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign dwr_hit[g] = vld_q[g] && (mem_q[g].kind == K_DWR);
    assign rrq_hit[g] = vld_q[g] && (mem_q[g].kind == K_RREQ);
  end

  assign has_dwr_o  = |dwr_hit;
  assign has_rreq_o = |rrq_hit;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(wp_q))); // R7

  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($countones(vld_q) == int'(cnt_q))); // R3
endmodule

// File: rtl/nhf_strobe.sv
module nhf_strobe
  import nhf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [DLY_W-1:0] wr_dly_i,
  input  logic [DLY_W-1:0] rd_dly_i,
  input  logic             ready_i,
  input  wb_ent_t          head_i,
  input  logic             empty_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             cur_dwr_o,
  output logic             cur_rreq_o,
  output logic             wr_done_o,
  output logic             rd_done_o,
  output logic [7:0]       rd_byte_o,
  output logic             we_n_o,
  output logic             re_n_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic [7:0]       dq_o,
  output logic             dq_oe_o,
  input  logic [7:0]       dq_i
);
  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI} seq_st_e;

  seq_st_e          st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  wb_ent_t          ent_q, ent_d;
  logic [7:0]       rbyte_q, rbyte_d;
  logic             rdone_q, rdone_d, wdone_q, wdone_d;
  logic             wphase;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    ent_d   = ent_q;
    rbyte_d = rbyte_q;
    rdone_d = 1'b0;
    wdone_d = 1'b0;
    pop_o   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (!empty_i) begin
          if (head_i.kind == K_RREQ) begin
            if (ready_i) begin
              pop_o = 1'b1;
              ent_d = head_i;
              cnt_d = rd_dly_i;
              st_d  = S_RLO;
            end
          end else begin
            pop_o = 1'b1;
            ent_d = head_i;
            cnt_d = wr_dly_i;
            st_d  = S_WLO;
          end
        end
      end
      S_WLO: begin
        if (cnt_q == '0) st_d = S_WHI;
        else             cnt_d = cnt_q - DLY_W'(1);
      end
      S_WHI: begin
        wdone_d = (ent_q.kind == K_DWR);
        st_d    = S_IDLE;
      end
      S_RLO: begin
        if (cnt_q == '0) begin
          rbyte_d = dq_i;
          rdone_d = 1'b1;
          st_d    = S_RHI;
        end else begin
          cnt_d = cnt_q - DLY_W'(1);
        end
      end
      S_RHI:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      ent_q   <= '0;
      rbyte_q <= '0;
      rdone_q <= 1'b0;
      wdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ent_q   <= ent_d;
      rbyte_q <= rbyte_d;
      rdone_q <= rdone_d;
      wdone_q <= wdone_d;
    end
  end

  assign wphase     = (st_q == S_WLO) || (st_q == S_WHI);
  assign we_n_o     = (st_q != S_WLO);
  assign re_n_o     = (st_q != S_RLO);
  assign cle_o      = wphase && (ent_q.kind == K_CMD);
  assign ale_o      = wphase && (ent_q.kind == K_ADDR);
  assign dq_oe_o    = wphase;
  assign dq_o       = ent_q.val;
  assign busy_o     = (st_q != S_IDLE);
  assign cur_dwr_o  = wphase && (ent_q.kind == K_DWR);
  assign cur_rreq_o = (st_q == S_RLO) || (st_q == S_RHI);
  assign wr_done_o  = wdone_q;
  assign rd_done_o  = rdone_q;
  assign rd_byte_o  = rbyte_q;

  // Checker state: measured strobe widths against the delay latched at start
  logic [DLY_W:0]   chk_wlen_q, chk_rlen_q;
  logic [DLY_W-1:0] chk_wdly_q, chk_rdly_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chk_wlen_q <= '0;
      chk_rlen_q <= '0;
      chk_wdly_q <= '0;
      chk_rdly_q <= '0;
    end else begin
      chk_wlen_q <= we_n_o ? '0 : chk_wlen_q + (DLY_W+1)'(1);
      chk_rlen_q <= re_n_o ? '0 : chk_rlen_q + (DLY_W+1)'(1);
      if (pop_o && head_i.kind != K_RREQ) chk_wdly_q <= wr_dly_i;
      if (pop_o && head_i.kind == K_RREQ) chk_rdly_q <= rd_dly_i;
    end
  end

  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(we_n_o) |-> (chk_wlen_q == {1'b0, chk_wdly_q} + (DLY_W+1)'(1))); // R4

  AST_RE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(re_n_o) |-> (chk_rlen_q == {1'b0, chk_rdly_q} + (DLY_W+1)'(1))); // R5

  AST_READ_WAITS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!busy_o && !empty_i && head_i.kind == K_RREQ && !ready_i) |=> re_n_o); // R6

  AST_DQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!we_n_o && !$past(we_n_o)) |-> $stable(dq_o)); // R3
endmodule

// File: rtl/nand_host_fe.sv
module nand_host_fe
  import nhf_pkg::*;
#(
  parameter int WB_DEPTH    = 4,
  parameter int ECC_RST_CYC = 6
) (
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        bus_wr_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        irq_o,
  output logic        ecc_rst_o,
  output logic        cfg_wide16_o,
  output logic        cfg_pg512_o,
  output logic        nf_ce_n_o,
  output logic        nf_cle_o,
  output logic        nf_ale_o,
  output logic        nf_we_n_o,
  output logic        nf_re_n_o,
  output logic [7:0]  nf_dq_o,
  output logic        nf_dq_oe_o,
  input  logic [7:0]  nf_dq_i,
  input  logic        nf_rb_i
);
  localparam int EW = $clog2(ECC_RST_CYC + 1);

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_s1_q, rst_s2_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q;

  logic             rb_lvl, rb_rise;
  logic             q_wr;
  wb_ent_t          push_ent, head;
  logic             wb_full, wb_empty, has_dwr, has_rreq, pop;
  logic             seq_busy, cur_dwr, cur_rreq, wr_done, rd_done;
  logic [7:0]       rd_byte;
  logic [CT_W-1:0]  ctrl_q, ctrl_d;
  logic [EV_W-1:0]  mask_q, mask_d, evt_q, evt_d, evt_set, evt_clr;
  logic             full_d_q;
  logic             eccb_q, eccb_d;
  logic [EW-1:0]    eccc_q, eccc_d;
  logic             wr_ctrl, wr_mask, wr_evt, wr_ecc;
  logic             unused_wdata;

  nhf_sync u_rb_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .async_i (nf_rb_i),
    .level_o (rb_lvl),
    .rise_o  (rb_rise)
  );

  // Offsets 4..7 feed the buffer; the low two bits give the entry kind
  assign q_wr          = bus_wr_i && (bus_addr_i[3:2] == 2'b01);
  assign push_ent.kind = ent_kind_e'(bus_addr_i[1:0]);
  assign push_ent.val  = bus_wdata_i[7:0];

  nhf_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .push_i     (q_wr),
    .push_ent_i (push_ent),
    .pop_i      (pop),
    .head_o     (head),
    .full_o     (wb_full),
    .empty_o    (wb_empty),
    .has_dwr_o  (has_dwr),
    .has_rreq_o (has_rreq)
  );

  nhf_strobe u_seq (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .wr_dly_i   (ctrl_q[3:0]),
    .rd_dly_i   (ctrl_q[7:4]),
    .ready_i    (rb_lvl),
    .head_i     (head),
    .empty_i    (wb_empty),
    .pop_o      (pop),
    .busy_o     (seq_busy),
    .cur_dwr_o  (cur_dwr),
    .cur_rreq_o (cur_rreq),
    .wr_done_o  (wr_done),
    .rd_done_o  (rd_done),
    .rd_byte_o  (rd_byte),
    .we_n_o     (nf_we_n_o),
    .re_n_o     (nf_re_n_o),
    .cle_o      (nf_cle_o),
    .ale_o      (nf_ale_o),
    .dq_o       (nf_dq_o),
    .dq_oe_o    (nf_dq_oe_o),
    .dq_i       (nf_dq_i)
  );

  assign wr_ctrl = bus_wr_i && (bus_addr_i == RA_CTRL);
  assign wr_mask = bus_wr_i && (bus_addr_i == RA_MASK);
  assign wr_evt  = bus_wr_i && (bus_addr_i == RA_EVT);
  assign wr_ecc  = bus_wr_i && (bus_addr_i == RA_ECCR);

  always_comb begin
    evt_set           = '0;
    evt_set[EV_NBSY]  = rb_rise;
    evt_set[EV_OVF]   = q_wr && wb_full;
    evt_set[EV_EDGE]  = full_d_q && !wb_full;
    evt_set[EV_RDRDY] = rd_done;
    evt_set[EV_WDONE] = wr_done && !has_dwr;
    evt_clr           = wr_evt ? bus_wdata_i[EV_W-1:0] : '0;
    evt_d             = (evt_q & ~evt_clr) | evt_set;

    ctrl_d = wr_ctrl ? bus_wdata_i[CT_W-1:0] : ctrl_q;
    mask_d = wr_mask ? bus_wdata_i[EV_W-1:0] : mask_q;

    eccb_d = eccb_q;
    eccc_d = eccc_q;
    if (eccb_q) begin
      if (eccc_q == '0) eccb_d = 1'b0;
      else              eccc_d = eccc_q - EW'(1);
    end else if (wr_ecc && bus_wdata_i[0]) begin
      eccb_d = 1'b1;
      eccc_d = EW'(ECC_RST_CYC - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      evt_q    <= '0;
      full_d_q <= 1'b0;
      eccb_q   <= 1'b0;
      eccc_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      mask_q   <= mask_d;
      evt_q    <= evt_d;
      full_d_q <= wb_full;
      eccb_q   <= eccb_d;
      eccc_q   <= eccc_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      RA_CTRL: bus_rdata_o[CT_W-1:0] = ctrl_q;
      RA_STAT: bus_rdata_o[4:0] = {wb_empty, has_rreq | cur_rreq,
                                   has_dwr | cur_dwr, wb_full, rb_lvl};
      RA_EVT:  bus_rdata_o[EV_W-1:0] = evt_q;
      RA_MASK: bus_rdata_o[EV_W-1:0] = mask_q;
      RA_RDAT: bus_rdata_o[7:0] = rd_byte;
      RA_ECCR: bus_rdata_o[0] = eccb_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o        = |(evt_q & mask_q);
  assign ecc_rst_o    = eccb_q;
  assign cfg_wide16_o = ctrl_q[8];
  assign cfg_pg512_o  = ctrl_q[9];
  assign nf_ce_n_o    = !(seq_busy || !wb_empty);
  assign unused_wdata = ^bus_wdata_i[15:CT_W];

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_evt && bus_wdata_i[EV_RDRDY] && !rd_done) |=> !evt_q[EV_RDRDY]); // R11

  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    (q_wr && wb_full) |=> evt_q[EV_OVF]); // R7

  AST_CE_COVERS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!nf_we_n_o || !nf_re_n_o) |-> !nf_ce_n_o); // R14

  AST_ECC_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (eccb_q && eccc_q == '0) |=> !eccb_q); // R13
endmodule

// File: tb/nand_host_fe_tb.sv
module nand_host_fe_tb;
  localparam int ECC_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq, ecc_rst, wide16, pg512;
  logic        ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  flash_byte = 8'h00;
  logic        rb = 1'b1;

  always #10 clk = ~clk;

  nand_host_fe #(.WB_DEPTH(4), .ECC_RST_CYC(ECC_CYC)) u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq),
    .ecc_rst_o(ecc_rst), .cfg_wide16_o(wide16), .cfg_pg512_o(pg512),
    .nf_ce_n_o(ce_n), .nf_cle_o(cle), .nf_ale_o(ale), .nf_we_n_o(we_n),
    .nf_re_n_o(re_n), .nf_dq_o(dq_o), .nf_dq_oe_o(dq_oe), .nf_dq_i(flash_byte),
    .nf_rb_i(rb)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // Pin monitor, sampled at falling edges
  int mon_kind [0:2047];
  int mon_val  [0:2047];
  int mon_len  [0:2047];
  int mon_n = 0, we_run = 0, re_run = 0, rd_n = 0, rd_last_len = 0;
  int cur_kind = 0, cur_val = 0, ce_bad = 0, pin_bad = 0, re_blocked = 0;
  bit rb_window = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) begin
        we_run++;
        cur_kind = cle ? 0 : (ale ? 1 : 2);
        cur_val  = dq_o;
        if (cle && ale) pin_bad++;
        if (!dq_oe) pin_bad++;
      end else if (we_run != 0) begin
        mon_kind[mon_n] = cur_kind;
        mon_val[mon_n]  = cur_val;
        mon_len[mon_n]  = we_run;
        mon_n++;
        we_run = 0;
      end
      if (!re_n) begin
        re_run++;
        if (rb_window) re_blocked++;
      end else if (re_run != 0) begin
        rd_last_len = re_run;
        rd_n++;
        re_run = 0;
      end
      if ((!we_n || !re_n) && ce_n) ce_bad++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (ce_n !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_rdrdy();
    logic [15:0] v;
    br(4'd2, v);
    for (int n = 0; n < 500 && !v[3]; n++) begin
      @(negedge clk);
      br(4'd2, v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int base, n, wd, rdl, k, x, r0;
    int exp_k [0:7];
    int exp_v [0:7];
    x = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    br(4'd0, v); chk("R1 ctrl reset", v, 0);
    br(4'd1, v); chk("R2 status reset", v, 16'h0011);
    br(4'd2, v); chk("R11 events reset", v, 0);
    br(4'd3, v); chk("R12 mask reset", v, 0);
    chk("R12 irq reset", irq, 0);
    chk("R14 ce idle", ce_n, 1);
    br(4'd9, v); chk("R13 ecc bit reset", v, 0);

    // Control register fields
    bw(4'd0, 16'hFFFF);
    br(4'd0, v); chk("R1 ctrl mask", v, 16'h03FF);
    chk("R1 wide out", wide16, 1);
    chk("R1 pg512 out", pg512, 1);
    bw(4'd0, 16'h0032);
    chk("R1 pg512 clear", pg512, 0);

    // Directed write sequence
    base = mon_n;
    bw(4'd4, 16'h0080);
    bw(4'd5, 16'h0012);
    bw(4'd6, 16'h005A);
    br(4'd1, v); chk("R10 write pending", v[2], 1);
    chk("R14 ce busy", ce_n, 0);
    wait_idle();
    chk("R3 entry count", mon_n - base, 3);
    chk("R3 cmd kind", mon_kind[base], 0);
    chk("R3 cmd val", mon_val[base], 8'h80);
    chk("R3 addr kind", mon_kind[base+1], 1);
    chk("R3 addr val", mon_val[base+1], 8'h12);
    chk("R3 data kind", mon_kind[base+2], 2);
    chk("R3 data val", mon_val[base+2], 8'h5A);
    chk("R4 we width", mon_len[base], 3);
    br(4'd2, v); chk("R10 page write done", v, 16'h0010);
    br(4'd1, v); chk("R10 pending clear", v[2], 0);
    bw(4'd2, 16'h0010);
    br(4'd2, v); chk("R11 w1c clear", v, 0);

    // Directed read
    flash_byte = 8'hC3;
    r0 = rd_n;
    bw(4'd7, 16'h1234);
    br(4'd1, v); chk("R5 read pending", v[3], 1);
    wait_rdrdy();
    br(4'd2, v); chk("R5 read ready flag", v[3], 1);
    br(4'd8, v); chk("R5 read data", v, 16'h00C3);
    chk("R5 re width", rd_last_len, 4);
    chk("R5 one read", rd_n - r0, 1);
    wait_idle();
    bw(4'd2, 16'h001F);

    // Busy device: fill, overflow, drain
    @(negedge clk); rb = 1'b0;
    repeat (4) @(negedge clk);
    br(4'd1, v); chk("R2 not ready", v[0], 0);
    rb_window = 1;
    r0 = rd_n;
    for (int i = 0; i < 4; i++) bw(4'd7, 16'h0000);
    br(4'd1, v); chk("R7 full", v[1], 1);
    chk("R5 read pending busy", v[3], 1);
    br(4'd2, v); chk("R7 no ovf yet", v[1], 0);
    bw(4'd7, 16'h0000);
    br(4'd2, v); chk("R7 ovf flag", v[1], 1);
    repeat (20) @(negedge clk);
    chk("R6 no read while busy", rd_n - r0, 0);
    chk("R6 re stayed high", re_blocked, 0);
    chk("R12 masked irq", irq, 0);
    bw(4'd3, 16'h0002);
    chk("R12 irq enabled", irq, 1);
    bw(4'd3, 16'h0000);
    chk("R12 irq masked again", irq, 0);
    rb_window = 0;
    rb = 1'b1;
    @(negedge clk); @(negedge clk);
    br(4'd2, v); chk("R9 not yet", v[0], 0);
    @(negedge clk);
    br(4'd2, v); chk("R9 ready edge", v[0], 1);
    wait_idle();
    chk("R7 dropped write", rd_n - r0, 4);
    br(4'd2, v); chk("R8 edge flag", v[2], 1);
    chk("R5 ready after drain", v[3], 1);
    bw(4'd2, 16'h0002);
    br(4'd2, v); chk("R11 partial clear", v, 16'h000D);
    bw(4'd2, 16'h001F);

    // Checksum-engine reset bit
    bw(4'd9, 16'h0001);
    br(4'd9, v); chk("R13 set", v, 1);
    chk("R13 output", ecc_rst, 1);
    repeat (ECC_CYC - 1) @(negedge clk);
    br(4'd9, v); chk("R13 still set", v, 1);
    @(negedge clk);
    br(4'd9, v); chk("R13 cleared", v, 0);

    // Random sequences
    for (int it = 0; it < 40; it++) begin
      wd  = (it == 0) ? 0 : (it == 1) ? 15 : int'($urandom % 16);
      rdl = (it == 0) ? 15 : (it == 1) ? 0 : int'($urandom % 16);
      bw(4'd0, 16'((rdl << 4) | wd));
      base = mon_n;
      n = 1 + int'($urandom % 6);
      for (int j = 0; j < n; j++) begin
        br(4'd1, v);
        while (v[1]) begin
          @(negedge clk);
          br(4'd1, v);
        end
        k = int'($urandom % 3);
        exp_k[j] = k;
        exp_v[j] = int'($urandom % 256);
        bw(4'(4 + k), 16'(exp_v[j]));
      end
      wait_idle();
      chk("R3 random count", mon_n - base, n);
      for (int j = 0; j < n; j++) begin
        chk("R3 random kind", mon_kind[base+j], exp_k[j]);
        chk("R3 random val", mon_val[base+j], exp_v[j]);
        chk("R4 random width", mon_len[base+j], wd + 1);
      end
      bw(4'd2, 16'h001F);
      flash_byte = 8'($urandom % 256);
      bw(4'd7, 16'h0000);
      wait_rdrdy();
      br(4'd8, v); chk("R5 random data", v, int'(flash_byte));
      chk("R5 random re width", rd_last_len, rdl + 1);
      wait_idle();
    end

    chk("R14 ce covered strobes", ce_bad, 0);
    chk("R3 pin exclusivity", pin_bad, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule